// File: doc/BRIEF.md
# Internal Data-Move Engine

This block carries out the internal data-transfer operations of an 8-bit accumulator-based microcontroller. It receives a command that has already been decoded: an operation, a source mode, a destination mode, a register index, two direct addresses and an immediate word. A single-clock start strobe launches the command. The block holds the state that these operations touch. That state is the accumulator, a 32-byte register area with four banks of eight, a stack pointer, a 16-bit data pointer, a lower RAM of 128 bytes, an upper RAM of 128 bytes that only indirect and stack accesses reach, and a small special-function register file.

Each operation form costs a fixed number of machine cycles, and one machine cycle is `MC_CLKS` clocks. The block latches the command when it accepts start. It commits the whole result on the last clock of the last machine cycle and raises done for one clock after that. Software-visible state reaches the ports as the accumulator, the stack pointer and the data pointer. A caller inspects any other location by moving it into the accumulator.

Top module: `dmove_engine`

## Requirements
- R1: A direct address below 80h selects lower RAM, and a direct address of 80h or above selects the special-function space. The SFR map is: accumulator E0h, B F0h, stack pointer 81h, data pointer low 82h, data pointer high 83h, and four port latches at 80h, 90h, A0h and B0h. Other SFR addresses read as 00h and ignore writes.
- R2: An indirect access (mode code 3) uses the value of R0 or R1 (register index bit 0) of the current bank as its address. It reaches RAM over the whole range 00h–FFh, with addresses of 80h and above in the upper RAM, and never reaches an SFR.
- R3: Register mode (code 1) with index n in bank b (bank_i) addresses lower RAM location 8·b+n, so R0 of bank 0 is RAM 00h.
- R4: A push (op code 3) first adds one to the stack pointer and then stores the direct source byte at RAM[new SP].
- R5: A pop (op code 4) copies RAM[SP] to the direct destination and then subtracts one from the stack pointer.
- R6: An exchange (op code 1) swaps a whole byte between the accumulator and a register, direct or indirect source operand.
- R7: A digit exchange (op code 2) swaps only the low nibbles of the accumulator and the indirect operand, and keeps both high nibbles.
- R8: A pointer load (op code 5) writes imm_i to the data pointer and takes 2 machine cycles.
- R9: These forms take 1 machine cycle: moves into the accumulator from a register, direct, indirect or immediate source; A or an immediate into a register; A into a direct or indirect location; and every exchange form. Op code 0 is a move, and the mode codes are 0 accumulator, 1 register, 2 direct, 3 indirect and 4 immediate.
- R10: These forms take 2 machine cycles: a direct byte into a register; a register, direct, indirect or immediate source into a direct location; a direct or immediate source into an indirect location; push; and pop.
- R11: A direct-to-direct move reads its source before it writes its destination, so a move of a location onto itself leaves the location unchanged.
- R12: After reset the stack pointer is 07h and the accumulator, data pointer and SFR latches are 00h. Stack accesses always use RAM, so a push that takes SP to 80h writes upper RAM and leaves the 80h port latch untouched.
- R13: done_o is high for exactly one clock, starting the clock after the last machine cycle. A start strobe that arrives while an operation is running is ignored and changes neither its result nor its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| op_i | input | 3 | Operation code |
| src_md_i | input | 3 | Source mode code |
| dst_md_i | input | 3 | Destination mode code |
| ridx_i | input | 3 | Register index; bit 0 picks R0/R1 for indirect |
| saddr_i | input | 8 | Direct source address |
| daddr_i | input | 8 | Direct destination address |
| imm_i | input | 16 | Immediate; low byte for 8-bit immediates |
| bank_i | input | 2 | Register bank select |
| done_o | output | 1 | One-clock completion pulse |
| acc_o | output | 8 | Accumulator |
| sp_o | output | 8 | Stack pointer |
| dptr_o | output | 16 | Data pointer |

## Verification
Addresses 90h and 80h are used both directly and through R0. A wrong map that folds the upper indirect RAM onto the port latches, or one that steers a stack access into the SFRs, then shows up as a wrong accumulator value. Register writes are made in bank 2 and read back through their RAM alias. A bank-0 register is also read back through address 00h. Together these show whether the bank offset is applied. Exchanges start from distinct byte pairs such as 12h/34h and CDh/ABh, so a full swap, a nibble swap and a one-sided copy all give different results. Each command's measured latency is compared with its cost class. A second start during a busy window carries a different, longer command, so a wrongly accepted strobe changes both the result and the latency.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0, OP_XCH = 3'd1, OP_XCHD = 3'd2,
    OP_PUSH = 3'd3, OP_POP = 3'd4, OP_LDPTR = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    MD_ACC = 3'd0, MD_REG = 3'd1, MD_DIR = 3'd2, MD_IND = 3'd3, MD_IMM = 3'd4
  } md_e;

  // location id: bit 8 set = special-function space, else RAM 00h-FFh
  typedef logic [8:0] loc_t;

  localparam logic [7:0] A_P0 = 8'h80, A_SP = 8'h81, A_DPL = 8'h82, A_DPH = 8'h83;
  localparam logic [7:0] A_P1 = 8'h90, A_P2 = 8'hA0, A_P3 = 8'hB0;
  localparam logic [7:0] A_ACC = 8'hE0, A_B = 8'hF0;

  // true when the form costs two machine cycles
  function automatic logic costs_two(op_e op, md_e s, md_e d);
    logic r;
    r = 1'b0;
    case (op)
      OP_LDPTR, OP_PUSH, OP_POP: r = 1'b1;
      OP_MOV: begin
        case (d)
          MD_REG:         r = (s == MD_DIR);
          MD_DIR, MD_IND: r = (s != MD_ACC);
          default:        r = 1'b0;
        endcase
      end
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // resolve an operand mode to a location id
  function automatic loc_t loc_of(md_e m, logic [2:0] ridx, logic [7:0] a,
                                  logic [1:0] bank, logic [7:0] ptr);
    loc_t l;
    case (m)
      MD_ACC:  l = {1'b1, A_ACC};
      MD_REG:  l = {1'b0, 3'b000, bank, ridx};
      MD_DIR:  l = {a[7], a};
      MD_IND:  l = {1'b0, ptr};
      default: l = '0;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/dmv_seq.sv
module dmv_seq #(
  parameter int MC_CLKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic two_mc,
  output logic accept,
  output logic fire,
  output logic done
);
  localparam int CW = $clog2(2 * MC_CLKS + 1);
  localparam logic [CW-1:0] ONE_MC = CW'(MC_CLKS);
  localparam logic [CW-1:0] TWO_MC = CW'(2 * MC_CLKS);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tot_q;

  assign accept = start && !busy_q;
  assign fire   = busy_q && (cnt_q == tot_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tot_q  <= ONE_MC;
      done   <= 1'b0;
    end else begin
      done <= fire;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        tot_q  <= two_mc ? TWO_MC : ONE_MC;
      end else if (busy_q) begin
        if (fire) busy_q <= 1'b0;
        else      cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R13
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !fire) |=> (busy_q && tot_q == $past(tot_q) && cnt_q == $past(cnt_q) + CW'(1))); // R13
endmodule

// File: rtl/dmv_exec.sv
module dmv_exec
  import dmv_pkg::*;
(
  input  logic        fire,
  input  logic [2:0]  op_i,
  input  logic [2:0]  src_md_i,
  input  logic [2:0]  dst_md_i,
  input  logic [2:0]  ridx_i,
  input  logic [7:0]  saddr_i,
  input  logic [7:0]  daddr_i,
  input  logic [15:0] imm_i,
  input  logic [1:0]  bank_i,
  input  logic [7:0]  acc,
  input  logic [7:0]  sp,
  input  logic [7:0]  ptr_rd,
  input  logic [7:0]  src_rd,
  output loc_t        ptr_loc,
  output loc_t        src_loc,
  output logic        w_en,
  output loc_t        w_loc,
  output logic [7:0]  w_dat,
  output logic        a_en,
  output logic [7:0]  a_dat,
  output logic        sp_en,
  output logic [7:0]  sp_dat,
  output logic        dp_en,
  output logic [15:0] dp_dat
);
  op_e  op;
  md_e  smd, dmd;
  loc_t dst_loc;

  assign op      = op_e'(op_i);
  assign smd     = md_e'(src_md_i);
  assign dmd     = md_e'(dst_md_i);
  assign ptr_loc = {1'b0, 3'b000, bank_i, 2'b00, ridx_i[0]};
  assign dst_loc = loc_of(dmd, ridx_i, daddr_i, bank_i, ptr_rd);

  always_comb begin
    case (op)
      OP_PUSH: src_loc = {saddr_i[7], saddr_i};
      OP_POP:  src_loc = {1'b0, sp};
      default: src_loc = loc_of(smd, ridx_i, saddr_i, bank_i, ptr_rd);
    endcase
  end

  always_comb begin
    w_en = 1'b0; w_loc = '0; w_dat = '0;
    a_en = 1'b0; a_dat = '0;
    sp_en = 1'b0; sp_dat = '0;
    dp_en = 1'b0; dp_dat = '0;
    case (op)
      OP_MOV: begin
        w_en  = fire && (dmd != MD_IMM);
        w_loc = dst_loc;
        w_dat = (smd == MD_IMM) ? imm_i[7:0] : src_rd;
      end
      OP_XCH: begin
        w_en  = fire; w_loc = src_loc; w_dat = acc;
        a_en  = fire; a_dat = src_rd;
      end
      OP_XCHD: begin
        w_en  = fire; w_loc = src_loc; w_dat = {src_rd[7:4], acc[3:0]};
        a_en  = fire; a_dat = {acc[7:4], src_rd[3:0]};
      end
      OP_PUSH: begin
        sp_en = fire; sp_dat = sp + 8'd1;
        w_en  = fire; w_loc = {1'b0, sp + 8'd1}; w_dat = src_rd;
      end
      OP_POP: begin
        sp_en = fire; sp_dat = sp - 8'd1;
        w_en  = fire; w_loc = {daddr_i[7], daddr_i}; w_dat = src_rd;
      end
      OP_LDPTR: begin
        dp_en = fire; dp_dat = imm_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dmv_store.sv
module dmv_store
  import dmv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  loc_t        ptr_loc,
  output logic [7:0]  ptr_rd,
  input  loc_t        src_loc,
  output logic [7:0]  src_rd,
  input  logic        w_en,
  input  loc_t        w_loc,
  input  logic [7:0]  w_dat,
  input  logic        a_en,
  input  logic [7:0]  a_dat,
  input  logic        sp_en,
  input  logic [7:0]  sp_dat,
  input  logic        dp_en,
  input  logic [15:0] dp_dat,
  output logic [7:0]  acc,
  output logic [7:0]  sp,
  output logic [15:0] dptr
);
  localparam int HALF = 1 << (DW - 1);
  localparam int HW   = DW - 1;
  localparam int NSFR = 9;
  localparam int I_ACC = 0, I_SP = 2, I_DPL = 3, I_DPH = 4;

  function automatic logic [7:0] sfr_addr(int i);
    case (i)
      0: return A_ACC;
      1: return A_B;
      2: return A_SP;
      3: return A_DPL;
      4: return A_DPH;
      5: return A_P0;
      6: return A_P1;
      7: return A_P2;
      default: return A_P3;
    endcase
  endfunction

  logic [7:0] lo_ram [HALF];
  logic [7:0] hi_ram [HALF];
  logic [NSFR-1:0][7:0] sfr_v;
  logic [7:0] src_sfr;
  logic       ram_wr;

  for (genvar gi = 0; gi < NSFR; gi++) begin : g_sfr
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= (gi == I_SP) ? 8'h07 : 8'h00;
      else if (w_en && w_loc == {1'b1, sfr_addr(gi)})
        q <= w_dat;
      else if (gi == I_ACC && a_en)
        q <= a_dat;
      else if (gi == I_SP && sp_en)
        q <= sp_dat;
      else if (gi == I_DPL && dp_en)
        q <= dp_dat[7:0];
      else if (gi == I_DPH && dp_en)
        q <= dp_dat[15:8];
    end
    assign sfr_v[gi] = q;
  end

  always_comb begin
    src_sfr = 8'h00;
    for (int i = 0; i < NSFR; i++)
      if (src_loc[7:0] == sfr_addr(i)) src_sfr = sfr_v[i];
  end

  assign ram_wr = w_en && !w_loc[8];

  always_ff @(posedge clk) begin
    if (ram_wr) begin
      if (w_loc[7]) hi_ram[w_loc[HW-1:0]] <= w_dat;
      else          lo_ram[w_loc[HW-1:0]] <= w_dat;
    end
  end

  assign ptr_rd = lo_ram[ptr_loc[HW-1:0]];
  assign src_rd = src_loc[8] ? src_sfr
                : (src_loc[7] ? hi_ram[src_loc[HW-1:0]] : lo_ram[src_loc[HW-1:0]]);

  assign acc  = sfr_v[I_ACC];
  assign sp   = sfr_v[I_SP];
  assign dptr = {sfr_v[I_DPH], sfr_v[I_DPL]};

  AST_RAM_WR_KEEPS_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr && !a_en && !sp_en && !dp_en) |=> (sfr_v == $past(sfr_v))); // R2
endmodule

// File: rtl/dmove_engine.sv
module dmove_engine
  import dmv_pkg::*;
#(
  parameter int MC_CLKS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op_i,
  input  logic [2:0]  src_md_i,
  input  logic [2:0]  dst_md_i,
  input  logic [2:0]  ridx_i,
  input  logic [7:0]  saddr_i,
  input  logic [7:0]  daddr_i,
  input  logic [15:0] imm_i,
  input  logic [1:0]  bank_i,
  output logic        done_o,
  output logic [7:0]  acc_o,
  output logic [7:0]  sp_o,
  output logic [15:0] dptr_o
);
  logic        accept, fire, two_mc;
  logic [2:0]  op_q, smd_q, dmd_q, ridx_q;
  logic [7:0]  saddr_q, daddr_q;
  logic [15:0] imm_q;
  logic [1:0]  bank_q;

  loc_t        ptr_loc, src_loc, w_loc;
  logic [7:0]  ptr_rd, src_rd, w_dat, a_dat, sp_dat;
  logic [15:0] dp_dat;
  logic        w_en, a_en, sp_en, dp_en;

  assign two_mc = costs_two(op_e'(op_i), md_e'(src_md_i), md_e'(dst_md_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; smd_q <= '0; dmd_q <= '0; ridx_q <= '0;
      saddr_q <= '0; daddr_q <= '0; imm_q <= '0; bank_q <= '0;
    end else if (accept) begin
      op_q <= op_i; smd_q <= src_md_i; dmd_q <= dst_md_i; ridx_q <= ridx_i;
      saddr_q <= saddr_i; daddr_q <= daddr_i; imm_q <= imm_i; bank_q <= bank_i;
    end
  end

  dmv_seq #(.MC_CLKS(MC_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .two_mc(two_mc),
    .accept(accept), .fire(fire), .done(done_o)
  );

  dmv_exec u_exec (
    .fire(fire), .op_i(op_q), .src_md_i(smd_q), .dst_md_i(dmd_q), .ridx_i(ridx_q),
    .saddr_i(saddr_q), .daddr_i(daddr_q), .imm_i(imm_q), .bank_i(bank_q),
    .acc(acc_o), .sp(sp_o), .ptr_rd(ptr_rd), .src_rd(src_rd),
    .ptr_loc(ptr_loc), .src_loc(src_loc),
    .w_en(w_en), .w_loc(w_loc), .w_dat(w_dat), .a_en(a_en), .a_dat(a_dat),
    .sp_en(sp_en), .sp_dat(sp_dat), .dp_en(dp_en), .dp_dat(dp_dat)
  );

  dmv_store u_store (
    .clk(clk), .rst_n(rst_n),
    .ptr_loc(ptr_loc), .ptr_rd(ptr_rd), .src_loc(src_loc), .src_rd(src_rd),
    .w_en(w_en), .w_loc(w_loc), .w_dat(w_dat), .a_en(a_en), .a_dat(a_dat),
    .sp_en(sp_en), .sp_dat(sp_dat), .dp_en(dp_en), .dp_dat(dp_dat),
    .acc(acc_o), .sp(sp_o), .dptr(dptr_o)
  );

  AST_PUSH_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_q == OP_PUSH) |=> (sp_o == $past(sp_o) + 8'd1)); // R4
  AST_POP_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_q == OP_POP && daddr_q != A_SP) |=> (sp_o == $past(sp_o) - 8'd1)); // R5
  AST_XCH_TAKES_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_q == OP_XCH && smd_q == MD_REG) |=> (acc_o == $past(src_rd))); // R6
  AST_PTR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_q == OP_LDPTR) |=> (dptr_o == $past(imm_q))); // R8
  AST_IND_STAYS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && smd_q == MD_IND && op_q != OP_PUSH && op_q != OP_POP) |-> !src_loc[8]); // R2
endmodule

// File: tb/sim_dmove_engine.sv
module sim_dmove_engine;
  localparam int MC = 12;
  localparam logic [2:0] MOV = 0, XCH = 1, XCHD = 2, PSH = 3, POP = 4, LDP = 5;
  localparam logic [2:0] ACC = 0, REG = 1, DIR = 2, IND = 3, IMM = 4;

  typedef struct {
    logic [7:0]  acc;
    logic [7:0]  sp;
    logic [15:0] dp;
    int          clks;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op_i = '0, src_md_i = '0, dst_md_i = '0, ridx_i = '0;
  logic [7:0] saddr_i = '0, daddr_i = '0;
  logic [15:0] imm_i = '0;
  logic [1:0] bank_i = '0;
  logic done_o;
  logic [7:0] acc_o, sp_o;
  logic [15:0] dptr_o;

  int n_chk = 0, n_bad = 0, ncyc = 0, t0 = 0;
  bit inflight = 0;
  exp_t sb[$];
  logic [7:0] e_acc = 8'h00, e_sp = 8'h07;
  logic [15:0] e_dp = 16'h0000;

  always #5 clk = ~clk;

  dmove_engine #(.MC_CLKS(MC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .src_md_i(src_md_i),
    .dst_md_i(dst_md_i), .ridx_i(ridx_i), .saddr_i(saddr_i), .daddr_i(daddr_i),
    .imm_i(imm_i), .bank_i(bank_i), .done_o(done_o), .acc_o(acc_o),
    .sp_o(sp_o), .dptr_o(dptr_o)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops expected items as done pulses arrive
  always @(negedge clk) begin
    exp_t e;
    ncyc++;
    if (rst_n && done_o) begin
      if (!inflight || sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R13 spurious done: actual 1 expected 0");
      end else begin
        e = sb.pop_front();
        chk(e.tag, "acc", acc_o, e.acc);
        chk(e.tag, "sp", sp_o, e.sp);
        chk(e.tag, "dptr", dptr_o, e.dp);
        chk(e.tag, "latency", ncyc - t0, e.clks);
        inflight = 0;
      end
    end
    if (rst_n && start && !inflight) begin
      t0 = ncyc;
      inflight = 1;
    end
    if (ncyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", ncyc);
      summary();
    end
  end

  // driver: launch one command, push its expected outcome, wait for completion
  task automatic run(logic [2:0] op, logic [2:0] s, logic [2:0] d, logic [2:0] r,
                     logic [7:0] sa, logic [7:0] da, logic [15:0] im, logic [1:0] bk,
                     int mcs, string tag, bit jam = 0);
    exp_t e;
    e.acc = e_acc; e.sp = e_sp; e.dp = e_dp; e.clks = mcs * MC; e.tag = tag;
    sb.push_back(e);
    @(negedge clk); #1;
    op_i = op; src_md_i = s; dst_md_i = d; ridx_i = r;
    saddr_i = sa; daddr_i = da; imm_i = im; bank_i = bk; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (jam) begin
      // a longer, different command strobed mid-operation must be dropped
      @(negedge clk); #1;
      op_i = LDP; imm_i = 16'h1234; src_md_i = IMM; dst_md_i = ACC; start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    wait (inflight == 0 && sb.size() == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "reset acc", acc_o, 8'h00);
    chk("R12", "reset sp", sp_o, 8'h07);
    chk("R12", "reset dptr", dptr_o, 16'h0000);
    chk("R13", "reset done", done_o, 1'b0);

    e_acc = 8'h3C; run(MOV, IMM, ACC, 0, 0, 0, 16'h003C, 0, 1, "R9 mov A,#imm");
    run(MOV, IMM, DIR, 0, 0, 8'h30, 16'h00A5, 0, 2, "R10 mov dir,#imm");
    e_acc = 8'hA5; run(MOV, DIR, ACC, 0, 8'h30, 0, 0, 0, 1, "R1 lower ram direct");
    run(MOV, IMM, DIR, 0, 0, 8'h90, 16'h005A, 0, 2, "R10 mov sfr,#imm");
    run(MOV, IMM, REG, 0, 0, 0, 16'h0090, 0, 1, "R9 mov R0,#imm");
    run(MOV, IMM, IND, 0, 0, 0, 16'h00C3, 0, 2, "R10 mov @R0,#imm");
    e_acc = 8'h5A; run(MOV, DIR, ACC, 0, 8'h90, 0, 0, 0, 1, "R1 sfr direct read");
    e_acc = 8'hC3; run(MOV, IND, ACC, 0, 0, 0, 0, 0, 1, "R2 upper ram indirect");
    e_acc = 8'h90; run(MOV, DIR, ACC, 0, 8'h00, 0, 0, 0, 1, "R3 R0 alias at 00h");
    run(MOV, IMM, REG, 3, 0, 0, 16'h0077, 2, 1, "R9 mov R3,#imm bank2");
    e_acc = 8'h77; run(MOV, DIR, ACC, 0, 8'h13, 0, 0, 0, 1, "R3 bank2 R3 at 13h");
    e_acc = 8'h00; run(MOV, IMM, ACC, 0, 0, 0, 16'h0000, 0, 1, "R9 clear A");
    e_acc = 8'h77; run(MOV, REG, ACC, 3, 0, 0, 0, 2, 1, "R3 mov A,R3 bank2");
    run(MOV, DIR, DIR, 0, 8'h30, 8'h31, 0, 0, 2, "R10 dir to dir");
    e_acc = 8'hA5; run(MOV, DIR, ACC, 0, 8'h31, 0, 0, 0, 1, "R11 copied byte");
    run(MOV, DIR, DIR, 0, 8'h30, 8'h30, 0, 0, 2, "R11 self move");
    e_acc = 8'h00; run(MOV, IMM, ACC, 0, 0, 0, 16'h0000, 0, 1, "R9 clear A");
    e_acc = 8'hA5; run(MOV, DIR, ACC, 0, 8'h30, 0, 0, 0, 1, "R11 self move kept");

    e_sp = 8'h08; run(PSH, DIR, DIR, 0, 8'h90, 0, 0, 0, 2, "R4 push");
    e_acc = 8'h5A; run(MOV, DIR, ACC, 0, 8'h08, 0, 0, 0, 1, "R4 pushed byte at new sp");
    e_sp = 8'h07; run(POP, DIR, DIR, 0, 0, 8'h32, 0, 0, 2, "R5 pop");
    e_acc = 8'h00; run(MOV, IMM, ACC, 0, 0, 0, 16'h0000, 0, 1, "R9 clear A");
    e_acc = 8'h5A; run(MOV, DIR, ACC, 0, 8'h32, 0, 0, 0, 1, "R5 popped byte");

    e_acc = 8'h12; run(MOV, IMM, ACC, 0, 0, 0, 16'h0012, 0, 1, "R9 mov A,#12");
    run(MOV, IMM, DIR, 0, 0, 8'h40, 16'h0034, 0, 2, "R10 mov 40h,#34");
    e_acc = 8'h34; run(XCH, DIR, ACC, 0, 8'h40, 0, 0, 0, 1, "R6 xch A,dir");
    e_acc = 8'h12; run(MOV, DIR, ACC, 0, 8'h40, 0, 0, 0, 1, "R6 xch dir side");
    e_acc = 8'h90; run(XCH, REG, ACC, 0, 0, 0, 0, 0, 1, "R6 xch A,R0");
    e_acc = 8'h12; run(MOV, DIR, ACC, 0, 8'h00, 0, 0, 0, 1, "R6 xch register side");

    run(MOV, IMM, REG, 1, 0, 0, 16'h0050, 0, 1, "R9 mov R1,#50");
    run(MOV, IMM, DIR, 0, 0, 8'h50, 16'h00AB, 0, 2, "R10 mov 50h,#AB");
    e_acc = 8'hCD; run(MOV, IMM, ACC, 0, 0, 0, 16'h00CD, 0, 1, "R9 mov A,#CD");
    e_acc = 8'hCB; run(XCHD, IND, ACC, 1, 0, 0, 0, 0, 1, "R7 xchd acc side");
    e_acc = 8'hAD; run(MOV, DIR, ACC, 0, 8'h50, 0, 0, 0, 1, "R7 xchd memory side");

    e_dp = 16'hF22C; run(LDP, IMM, ACC, 0, 0, 0, 16'hF22C, 0, 2, "R8 load pointer");
    e_acc = 8'h2C; run(MOV, DIR, ACC, 0, 8'h82, 0, 0, 0, 1, "R1 pointer low via sfr");
    e_acc = 8'hF2; run(MOV, DIR, ACC, 0, 8'h83, 0, 0, 0, 1, "R1 pointer high via sfr");

    e_sp = 8'h7F; run(MOV, IMM, DIR, 0, 0, 8'h81, 16'h007F, 0, 2, "R1 sp via sfr");
    e_sp = 8'h80; run(PSH, DIR, DIR, 0, 8'h30, 0, 0, 0, 2, "R12 push into upper ram");
    e_acc = 8'h00; run(MOV, DIR, ACC, 0, 8'h80, 0, 0, 0, 1, "R12 port latch untouched");
    run(MOV, IMM, REG, 0, 0, 0, 16'h0080, 0, 1, "R9 mov R0,#80");
    e_acc = 8'hA5; run(MOV, IND, ACC, 0, 0, 0, 0, 0, 1, "R12 stack byte in upper ram");

    e_acc = 8'h11; run(MOV, IMM, ACC, 0, 0, 0, 16'h0011, 0, 1, "R13 start ignored when busy", 1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule